// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block tells a DRAM controller when refresh cycles are owed and when host traffic must stand aside for them. A free-running timer marks out refresh obligations. In distributed mode one refresh is owed every refresh interval: 15.6 µs for standard parts, 125 µs for extended parts. In burst mode every row is refreshed in one contiguous run, once per retention period. The interval and period are given in nanoseconds and converted to clock cycles at elaboration.

The scheduler never interrupts an access that is already running. When a refresh is owed, it raises a hold-off so that the host starts no new command. It then waits for the access-busy flag to drop, and only after that asks the cycle sequencer for a refresh. The sequencer answers each refresh cycle with a one-cycle done pulse. The hold-off is released once nothing more is owed.

Obligations that expire while the controller is busy are counted, up to a parameter limit, so none is lost. Each counted obligation is then granted as its own refresh. Generating the refresh waveforms on the DRAM pins is the sequencer's job, not this block's.

Top module: `refresh_sched`

## Requirements
- R1: After reset, ref_req, host_hold and burst_active are low and no refresh is owed. The first obligation falls exactly one interval (or period) after reset is released.
- R2: With burst_mode low, a refresh becomes owed every INTERVAL_CYC = REF_INTERVAL_NS / CLK_PERIOD_NS cycles, whether or not earlier ones were serviced. host_hold is high in the cycle after the timer edge that creates the obligation.
- R3: host_hold stays high from the moment a refresh is owed until the done pulse that retires the last owed refresh. It is low in the following cycle.
- R4: While access_busy is high, ref_req stays low even when refresh is owed. When access_busy is sampled low with refresh owed, ref_req is high in the next cycle.
- R5: ref_req stays high through a single refresh until ref_done is sampled high. One done pulse completes one refresh, and ref_req is low in the following cycle.
- R6: Each expired interval adds one owed refresh, up to PEND_MAX, beyond which further expiries are dropped. Each owed refresh is granted as a separate ref_req/ref_done exchange.
- R7: A ref_done pulse while ref_req is low has no effect: nothing owed is retired and host_hold keeps its level.
- R8: With burst_mode high, a burst becomes owed every PERIOD_CYC = RETENTION_NS / CLK_PERIOD_NS cycles. Once started, ref_req stays high without a gap for ROWS done pulses.
- R9: burst_active rises together with ref_req for the first row of a burst. It falls, together with ref_req and host_hold, in the cycle after the done pulse of the last row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 1 = one burst per retention period, 0 = evenly spaced single refreshes |
| access_busy | input | 1 | High while a host read or write is still in progress |
| ref_done | input | 1 | One-cycle pulse from the sequencer when a refresh cycle finishes |
| ref_req | output | 1 | Asks the sequencer to run refresh cycles |
| host_hold | output | 1 | Blocks new host commands while refresh is owed or running |
| burst_active | output | 1 | High while a burst refresh is running |

## Verification
The bench builds the block with a 10 ns clock, a 200 ns interval (20 cycles), a 2000 ns period (200 cycles), 8 rows and a limit of 3 owed refreshes. At these values, five missed intervals fit in about a hundred cycles, so saturation can be reached and then drained one grant at a time. Two complete bursts, one of them delayed by a busy access, fit within a few hundred cycles. The short interval also allows the exact spacing of obligations, and the one-cycle response to access_busy, to be measured against several busy and done latencies.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_PERIOD_NS   = 10,
  parameter int REF_INTERVAL_NS = 15600,
  parameter int RETENTION_NS    = 16000000,
  parameter int ROWS            = 1024,
  parameter int PEND_MAX        = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic access_busy,
  input  logic ref_done,
  output logic ref_req,
  output logic host_hold,
  output logic burst_active
);
  localparam int INTERVAL_CYC = REF_INTERVAL_NS / CLK_PERIOD_NS;
  localparam int PERIOD_CYC   = RETENTION_NS / CLK_PERIOD_NS;
  localparam int TMR_MAX      = (PERIOD_CYC > INTERVAL_CYC) ? PERIOD_CYC : INTERVAL_CYC;
  localparam int TMR_W        = $clog2(TMR_MAX + 1);
  localparam int ROW_W        = (ROWS > 2) ? $clog2(ROWS) : 1;
  localparam int PEND_W       = $clog2(PEND_MAX + 1);
  localparam logic [TMR_W-1:0]  INT_LAST = TMR_W'(INTERVAL_CYC - 1);
  localparam logic [TMR_W-1:0]  PER_LAST = TMR_W'(PERIOD_CYC - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  typedef enum logic [1:0] {S_IDLE, S_SINGLE, S_BURST} state_t;

  state_t            state;
  logic [TMR_W-1:0]  timer;
  logic [PEND_W-1:0] pending;
  logic [ROW_W-1:0]  row;

  logic tick, last_row, retire, start, inc;

  assign tick     = timer >= (burst_mode ? PER_LAST : INT_LAST);
  assign last_row = row == ROW_LAST;
  assign retire   = ref_done && (state == S_SINGLE || (state == S_BURST && last_row));
  assign start    = state == S_IDLE && pending != '0 && !access_busy;
  assign inc      = tick && (pending != PEND_TOP || retire);

  assign ref_req      = state != S_IDLE;
  assign host_hold    = ref_req || pending != '0;
  assign burst_active = state == S_BURST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer <= '0;
    else if (tick) timer <= '0;
    else timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else if (inc && !retire) pending <= pending + 1'b1;
    else if (!inc && retire) pending <= pending - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      row   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= burst_mode ? S_BURST : S_SINGLE;
          row   <= '0;
        end
        S_SINGLE: if (ref_done) state <= S_IDLE;
        S_BURST: if (ref_done) begin
          if (last_row) state <= S_IDLE;
          else row <= row + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_tick_owes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> host_hold);

  assert_hold_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_hold) |-> $past(ref_done));

  assert_wait_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req) |-> !$past(access_busy));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_done) |=> ref_req);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == PEND_TOP && !retire) |=> pending == PEND_TOP);

  assert_idle_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_req && ref_done && !tick) |=> pending == $past(pending));

  assert_burst_contig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !(ref_done && last_row)) |=> burst_active && ref_req);

  assert_burst_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $rose(ref_req));

  assert_burst_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_active) |-> $past(ref_done) && $past(last_row) && !ref_req);
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb_top;
  localparam int TCLK  = 10;
  localparam int LIM   = 20;
  localparam int PER   = 200;
  localparam int NROWS = 8;
  localparam int NVEC  = 4;

  typedef struct packed {
    logic [7:0] busy_len;
    logic [7:0] done_lat;
    logic [7:0] req_delay;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd0, 8'd0, 8'd1},
    '{8'd2, 8'd1, 8'd3},
    '{8'd5, 8'd3, 8'd6},
    '{8'd1, 8'd4, 8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_mode = 1'b0;
  logic access_busy = 1'b0;
  logic ref_done = 1'b0;
  logic ref_req, host_hold, burst_active;
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_sched #(
    .CLK_PERIOD_NS(10), .REF_INTERVAL_NS(200), .RETENTION_NS(2000),
    .ROWS(NROWS), .PEND_MAX(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .access_busy(access_busy),
    .ref_done(ref_done), .ref_req(ref_req), .host_hold(host_hold), .burst_active(burst_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic busy);
    rst_n = 1'b0;
    burst_mode = mode;
    access_busy = busy;
    ref_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_hold(output int at);
    int k = 0;
    while (!host_hold && k < 400) begin
      @(negedge clk);
      k++;
    end
    at = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int at, cnt, grants, dones, bad;

    // R1: reset state
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    chk("R1 ref_req", ref_req, 0);
    chk("R1 host_hold", host_hold, 0);
    chk("R1 burst_active", burst_active, 0);

    // distributed vectors
    for (int i = 0; i < NVEC; i++) begin
      wait_hold(at);
      chk(i == 0 ? "R1 first obligation" : "R2 interval", at, (i + 1) * LIM);
      cnt = 0;
      while (!ref_req && cnt < 16) begin
        if (cnt == int'(VECS[i].busy_len)) access_busy = 1'b0;
        @(negedge clk);
        cnt++;
      end
      chk("R4 req after busy", cnt, int'(VECS[i].req_delay));
      for (int j = 0; j < int'(VECS[i].done_lat); j++) @(negedge clk);
      chk("R5 req held", ref_req, 1);
      ref_done = 1'b1;
      @(negedge clk);
      ref_done = 1'b0;
      access_busy = 1'b1;
      chk("R5 req drop", ref_req, 0);
      chk("R3 hold drop", host_hold, 0);
    end

    // R6, R7: saturation and idle done pulses
    do_reset(1'b0, 1'b1);
    wait_cyc(LIM + 5);
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
    chk("R7 hold kept", host_hold, 1);
    chk("R7 no req", ref_req, 0);
    wait_cyc(3 * LIM + 5);
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
    wait_cyc(5 * LIM + 2);
    chk("R6 hold while busy", host_hold, 1);
    access_busy = 1'b0;
    grants = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (ref_done) ref_done = 1'b0;
      else if (ref_req) begin
        ref_done = 1'b1;
        grants++;
      end
      if (!host_hold && !ref_done) break;
    end
    chk("R6 grants after saturation", grants, 3);
    chk("R3 hold after drain", host_hold, 0);

    // R8, R9: burst mode
    do_reset(1'b1, 1'b0);
    wait_hold(at);
    chk("R8 period", at, PER);
    @(negedge clk);
    chk("R9 burst rise", burst_active, 1);
    chk("R9 req with burst", ref_req, 1);
    dones = 0;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (!ref_req) break;
      if (!burst_active || !host_hold) bad++;
      ref_done = 1'b1;
      dones++;
      @(negedge clk);
    end
    ref_done = 1'b0;
    chk("R8 rows per burst", dones, NROWS);
    chk("R9 active throughout", bad, 0);
    chk("R9 burst fall", burst_active, 0);
    chk("R9 hold fall", host_hold, 0);

    access_busy = 1'b1;
    wait_cyc(2 * PER);
    chk("R8 second period", host_hold, 1);
    chk("R4 burst waits busy", ref_req, 0);
    @(negedge clk);
    @(negedge clk);
    access_busy = 1'b0;
    @(negedge clk);
    chk("R4 burst starts", ref_req, 1);
    dones = 0;
    for (int k = 0; k < 40; k++) begin
      if (!ref_req) break;
      ref_done = 1'b1;
      dones++;
      @(negedge clk);
    end
    ref_done = 1'b0;
    chk("R8 second burst rows", dones, NROWS);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule